// File: doc/BRIEF.md
# Serial Bit Stuffing Encoder and Decoder

This block applies the run-length rule used on a CAN-style serial line to the part of a frame where stuffing is active. The transmit half watches the bits it sends. Once a run of identical bits reaches the limit, it puts one bit of the opposite level on the line. While that bit goes out, it holds off the upstream bit source for one bit time. The receive half watches the incoming line. It removes the opposite-level bit that ends a maximal run, and it raises a sticky error when a run grows one bit past the limit. A deliberate six-bit dominant error flag therefore always trips the error.

Both halves advance only on a single-clock bit strobe, which a bit timing unit elsewhere supplies. A region input frames the stuffed span of a frame, from start-of-frame to the end of the CRC sequence. Outside that span, bits pass through untouched and the run trackers are idle. Each time the region opens, the trackers restart, and the first bit forms a run of length one. The inserted bit counts as the first bit of a new run, so the line keeps seeing regular edges.

Top module: `bitstuff_codec`

## Requirements
- R1: After reset, tx_dout is 1 (recessive), tx_ready is 1, rx_valid is 0 and rx_err is 0.
- R2: With region_en high, after RUN_LEN (default 5) identical bits have been sent since the last level change or region start, the next strobe sends the complement of that level instead of tx_din. The inserted bit starts a new run of length 1.
- R3: tx_ready is 0 exactly during the bit time in which a stuff bit is due, so tx_din is not consumed at that strobe. tx_ready is 1 at the strobe right after a stuff bit.
- R4: With region_en high, a received bit that differs from the preceding RUN_LEN identical bits is discarded. No rx_valid pulse follows its strobe, and it starts a new run of length 1.
- R5: With region_en high, a received bit equal to the preceding RUN_LEN identical bits sets rx_err. This applies to both levels, including six dominant (0) bits. The offending bit is still delivered with rx_valid.
- R6: rx_err stays 1 until a clock edge at which region_en is 0, after which it reads 0.
- R7: With region_en low, nothing is inserted, removed or flagged. tx_ready stays 1, tx_dout copies tx_din, and every strobe yields an rx_valid pulse carrying rx_din.
- R8: Run tracking restarts whenever region_en has been low for at least one clock edge. Bits sent or received before the gap do not count toward a run after it.
- R9: tx_dout and rx_dout update at the clock edge where bit_stb is high. rx_valid is a one-clock pulse in the cycle after such an edge, and only for a delivered bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-clock pulse per bit time |
| region_en | input | 1 | High while inside the stuffed span of a frame |
| tx_din | input | 1 | Upstream transmit data bit |
| tx_ready | output | 1 | tx_din is taken at the next strobe |
| tx_dout | output | 1 | Stuffed serial line bit |
| rx_din | input | 1 | Serial line bit from the bus |
| rx_dout | output | 1 | Destuffed data bit |
| rx_valid | output | 1 | rx_dout holds a new data bit (one-clock pulse) |
| rx_err | output | 1 | Sticky stuff-rule violation |

## Verification
Every 10-bit data word is encoded and then decoded, with the expected line stream computed by an arithmetic run model. This sweep catches a design that stuffs after the wrong run length, forgets to restart the run on the inserted bit, or fails to undo its own stuffing. Directed runs of six zeros and of six ones target the error check, since an off-by-one tracker would let the error flag slip through or fire at the fifth bit. Further runs check that the flag stays up across later bits and clears only when the region closes. Long identical runs with the region closed, and short runs split by a region gap, expose stuffing that leaks outside the span or a run count that survives a restart.

// File: rtl/bitstuff_pkg.sv
package bitstuff_pkg;
   // counter must hold 0 .. RUN_LEN+1 (one past the limit marks a violation)
   function automatic int run_cnt_bits(input int run_len);
      return $clog2(run_len + 2);
   endfunction
endpackage

// File: rtl/bitstuff_run.sv
module bitstuff_run #(
   parameter int RUN_LEN = 5,
   parameter int CW      = bitstuff_pkg::run_cnt_bits(RUN_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          step,
   input  logic          bit_in,
   output logic          active,
   output logic          last,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LIM = CW'(RUN_LEN);
   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         last   <= 1'b1;
         cnt    <= '0;
      end else if (!en) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (step) begin
         active <= 1'b1;
         last   <= bit_in;
         if (!active || (bit_in != last)) cnt <= ONE;
         else if (cnt <= LIM)             cnt <= cnt + ONE;
      end
   end

   assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM + ONE);
   assert_run_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0) && !active);
endmodule

// File: rtl/bitstuff_tx.sv
module bitstuff_tx #(
   parameter int RUN_LEN = 5,
   parameter int CW      = bitstuff_pkg::run_cnt_bits(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic region_en,
   input  logic tx_din,
   output logic tx_ready,
   output logic tx_dout
);
   localparam logic [CW-1:0] LIM = CW'(RUN_LEN);

   logic          run_act;
   logic          run_last;
   logic [CW-1:0] run_cnt;
   logic          stuff_due;
   logic          line_bit;

   assign stuff_due = region_en && run_act && (run_cnt == LIM);
   assign line_bit  = stuff_due ? ~run_last : tx_din;
   assign tx_ready  = ~stuff_due;

   bitstuff_run #(.RUN_LEN(RUN_LEN), .CW(CW)) run_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (region_en),
      .step   (bit_stb),
      .bit_in (line_bit),
      .active (run_act),
      .last   (run_last),
      .cnt    (run_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_dout <= 1'b1;
      else if (bit_stb) tx_dout <= line_bit;
   end

   assert_stuff_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !tx_ready) |=> (tx_dout != $past(tx_dout)));
   assert_single_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !tx_ready) |=> tx_ready);
   assert_no_stall_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !region_en |-> tx_ready);
   assert_tx_run_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= LIM);
endmodule

// File: rtl/bitstuff_rx.sv
module bitstuff_rx #(
   parameter int RUN_LEN = 5,
   parameter int CW      = bitstuff_pkg::run_cnt_bits(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic region_en,
   input  logic rx_din,
   output logic rx_dout,
   output logic rx_valid,
   output logic rx_err
);
   localparam logic [CW-1:0] LIM = CW'(RUN_LEN);

   logic          run_act;
   logic          run_last;
   logic [CW-1:0] run_cnt;
   logic          at_limit;
   logic          drop_bit;
   logic          viol_bit;

   assign at_limit = region_en && run_act && (run_cnt >= LIM);
   assign drop_bit = at_limit && (run_cnt == LIM) && (rx_din != run_last);
   assign viol_bit = at_limit && (rx_din == run_last);

   bitstuff_run #(.RUN_LEN(RUN_LEN), .CW(CW)) run_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (region_en),
      .step   (bit_stb),
      .bit_in (rx_din),
      .active (run_act),
      .last   (run_last),
      .cnt    (run_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_dout  <= 1'b1;
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
      end else begin
         rx_valid <= bit_stb && !drop_bit;
         if (bit_stb && !drop_bit) rx_dout <= rx_din;
         if (!region_en)                rx_err <= 1'b0;
         else if (bit_stb && viol_bit)  rx_err <= 1'b1;
      end
   end

   assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bit_stb));
   assert_err_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && !$past(rx_err)) |-> $past(region_en && bit_stb));
   assert_err_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !region_en |=> !rx_err);
   assert_pass_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !region_en) |=> rx_valid);
endmodule

// File: rtl/bitstuff_codec.sv
module bitstuff_codec #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic region_en,
   input  logic tx_din,
   output logic tx_ready,
   output logic tx_dout,
   input  logic rx_din,
   output logic rx_dout,
   output logic rx_valid,
   output logic rx_err
);
   localparam int CW = bitstuff_pkg::run_cnt_bits(RUN_LEN);

   generate
      if (RUN_LEN < 2) begin : g_bad_run_len
         $error("bitstuff_codec: RUN_LEN must be at least 2");
      end
   endgenerate

   bitstuff_tx #(.RUN_LEN(RUN_LEN), .CW(CW)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .region_en (region_en),
      .tx_din    (tx_din),
      .tx_ready  (tx_ready),
      .tx_dout   (tx_dout)
   );

   bitstuff_rx #(.RUN_LEN(RUN_LEN), .CW(CW)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .region_en (region_en),
      .rx_din    (rx_din),
      .rx_dout   (rx_dout),
      .rx_valid  (rx_valid),
      .rx_err    (rx_err)
   );
endmodule

// File: tb/bitstuff_codec_tb_top.sv
`timescale 1ns/1ps
module bitstuff_codec_tb_top;
   localparam int RL  = 5;
   localparam int DW  = 10;
   localparam int MAXL = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0;
   logic region_en = 1'b0;
   logic tx_din = 1'b0;
   logic rx_din = 1'b1;
   logic tx_ready, tx_dout, rx_dout, rx_valid, rx_err;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   bitstuff_codec #(.RUN_LEN(RL)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .region_en(region_en),
      .tx_din(tx_din), .tx_ready(tx_ready), .tx_dout(tx_dout),
      .rx_din(rx_din), .rx_dout(rx_dout), .rx_valid(rx_valid), .rx_err(rx_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tx_step(input logic d, input logic reg_on, output logic cons, output logic ob);
      @(negedge clk);
      tx_din = d; region_en = reg_on; bit_stb = 1'b1;
      #1 cons = tx_ready;
      @(negedge clk);
      bit_stb = 1'b0;
      ob = tx_dout;
   endtask

   task automatic rx_step(input logic b, input logic reg_on, output logic v, output logic o, output logic e);
      @(negedge clk);
      rx_din = b; region_en = reg_on; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      v = rx_valid; o = rx_dout; e = rx_err;
   endtask

   task automatic region_gap();
      @(negedge clk);
      region_en = 1'b0; bit_stb = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic cons, ob, v, o, e;
      logic got [MAXL];
      logic expv [MAXL];
      logic dec [MAXL];
      int n, ne, m, run, i;
      logic last, any_err, seq_ok;
      logic [DW-1:0] pat;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_dout == 1'b1, "R1 tx_dout", tx_dout, 1);
      chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
      chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
      chk(rx_err == 1'b0, "R1 rx_err", rx_err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 R9: exhaustive encode then decode of every DW-bit word
      for (int w = 0; w < (1 << DW); w++) begin
         pat = DW'(w);
         // model of the stuffed line stream
         ne = 0; run = 0; last = 1'b1;
         for (int k = 0; k < DW; k++) begin
            if (run == RL) begin
               expv[ne] = ~last; ne++; last = ~last; run = 1;
            end
            expv[ne] = pat[k]; ne++;
            if (run == 0 || pat[k] != last) run = 1; else run++;
            last = pat[k];
         end
         // drive the transmitter
         i = 0; n = 0;
         while (i < DW && n < MAXL) begin
            tx_step(pat[i], 1'b1, cons, ob);
            got[n] = ob; n++;
            if (cons) i++;
         end
         region_gap();
         seq_ok = (n == ne);
         for (int k = 0; k < MAXL; k++) if (k < n && k < ne && got[k] != expv[k]) seq_ok = 1'b0;
         chk(seq_ok, "R2/R3 stuffed stream word", w, n);
         // feed the line stream back through the receiver
         m = 0; any_err = 1'b0;
         for (int k = 0; k < n; k++) begin
            rx_step(got[k], 1'b1, v, o, e);
            if (v && m < MAXL) begin dec[m] = o; m++; end
            any_err |= e;
         end
         region_gap();
         seq_ok = (m == DW) && !any_err;
         for (int k = 0; k < DW; k++) if (k < m && dec[k] != pat[k]) seq_ok = 1'b0;
         chk(seq_ok, "R4/R9 destuffed word", m, DW);
      end

      // R4: explicit drop of the stuff bit, valid low for it
      for (int k = 0; k < RL; k++) rx_step(1'b0, 1'b1, v, o, e);
      rx_step(1'b1, 1'b1, v, o, e);
      chk(v == 1'b0, "R4 stuff bit valid", v, 0);
      rx_step(1'b1, 1'b1, v, o, e);
      chk(v == 1'b1 && o == 1'b1 && e == 1'b0, "R4 bit after stuff", {v, o, e}, 3'b110);
      region_gap();

      // R5 R6: six dominant bits, then sticky flag, then clear
      for (int k = 0; k < RL; k++) rx_step(1'b0, 1'b1, v, o, e);
      chk(e == 1'b0, "R5 no error at limit", e, 0);
      rx_step(1'b0, 1'b0 | 1'b1, v, o, e);
      chk(e == 1'b1 && v == 1'b1, "R5 six dominant error", {e, v}, 2'b11);
      rx_step(1'b1, 1'b1, v, o, e);
      rx_step(1'b0, 1'b1, v, o, e);
      rx_step(1'b1, 1'b1, v, o, e);
      chk(e == 1'b1, "R6 error sticky", e, 1);
      region_gap();
      chk(rx_err == 1'b0, "R6 error cleared", rx_err, 0);

      // R5: six recessive bits
      for (int k = 0; k < RL + 1; k++) rx_step(1'b1, 1'b1, v, o, e);
      chk(e == 1'b1, "R5 six recessive error", e, 1);
      region_gap();

      // R7: long runs outside the region
      seq_ok = 1'b1;
      for (int k = 0; k < 2 * RL; k++) begin
         tx_step(1'b0, 1'b0, cons, ob);
         if (!cons || ob != 1'b0) seq_ok = 1'b0;
      end
      chk(seq_ok, "R7 tx passthrough", seq_ok, 1);
      seq_ok = 1'b1;
      for (int k = 0; k < 2 * RL; k++) begin
         rx_step(1'b0, 1'b0, v, o, e);
         if (!v || o != 1'b0 || e) seq_ok = 1'b0;
      end
      chk(seq_ok, "R7 rx passthrough", seq_ok, 1);

      // R8: a region gap restarts the run on both sides
      seq_ok = 1'b1;
      for (int k = 0; k < 3; k++) begin tx_step(1'b0, 1'b1, cons, ob); if (!cons) seq_ok = 1'b0; end
      region_gap();
      for (int k = 0; k < 3; k++) begin tx_step(1'b0, 1'b1, cons, ob); if (!cons || ob != 1'b0) seq_ok = 1'b0; end
      region_gap();
      chk(seq_ok, "R8 tx restart", seq_ok, 1);
      seq_ok = 1'b1;
      for (int k = 0; k < 3; k++) begin rx_step(1'b0, 1'b1, v, o, e); if (!v || e) seq_ok = 1'b0; end
      region_gap();
      for (int k = 0; k < 4; k++) begin rx_step(1'b0, 1'b1, v, o, e); if (!v || e) seq_ok = 1'b0; end
      region_gap();
      chk(seq_ok, "R8 rx restart", seq_ok, 1);

      // R9: rx_valid is a single-clock pulse
      rx_step(1'b1, 1'b0, v, o, e);
      @(negedge clk);
      chk(rx_valid == 1'b0, "R9 valid pulse width", rx_valid, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule